// File: doc/BRIEF.md
# Ultrasonic Time-of-Flight Counter

This block times the flight of an ultrasonic burst in cycles of the counting clock. The transmit enable that starts the pulse generator also starts the counter, so timing begins together with the first transmitted pulse. The count is kept as decimal digits. It runs until the echo detector on the receive side reports a rising edge. At that point counting stops and the captured count is written into a small result FIFO. A consumer drains the FIFO with a read request, and each result it reads is marked by a one-cycle valid strobe.

The echo input is asynchronous to the counting clock, so it passes through a synchronizer before the block acts on it. If no echo arrives before the counter reaches its top value, the measurement ends on its own with a saturated result and a sticky timeout flag. When a measurement has ended, the block ignores further transmit enables until a clear is applied. Clear also zeroes the digits, so the block is ready for the next burst. Results already in the FIFO survive a clear.

Top module: `tof_timer`

## Requirements
- R1: After reset, busy_o, timeout_o, res_valid_o and fifo_full_o are 0 and fifo_empty_o is 1.
- R2: When tx_en_i is sampled high in the idle state at clock edge 0, busy_o is 1 after that edge. If echo_i first goes high before edge m (m >= 1), the stored result is m+1: two synchronizer stages and one edge-detect stage. busy_o then returns to 0.
- R3: Only a low-to-high transition of the synchronized echo ends a measurement. An echo that rises while idle writes nothing. An echo that is already high when counting starts does not stop the count.
- R4: Results are BCD. Digit i occupies bits [4i+3:4i], with the least significant digit at [3:0]. Each digit stays in 0..9 and carries into the next digit when it wraps from 9 to 0.
- R5: If no echo rise arrives, counting stops one cycle after the count reaches 9999. The value 9999 (16'h9999) is written and timeout_o is set. timeout_o stays set until clr_i.
- R6: After a measurement has ended, tx_en_i is ignored until clr_i: busy_o stays 0 and nothing is written.
- R7: clr_i zeroes the count, clears timeout_o and returns the block to idle. It aborts a running measurement without writing, and it leaves the FIFO contents intact.
- R8: The FIFO holds 4 results in order and reports full and empty. A write while full is dropped.
- R9: A read request while the FIFO is not empty makes res_valid_o 1 for one cycle after that edge, with the oldest result on res_bcd_o. A read request while empty produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Shared transmit enable; starts a measurement |
| echo_i | input | 1 | Asynchronous echo detect from receiver |
| clr_i | input | 1 | Re-arm: zero count, clear timeout, go idle |
| rd_en_i | input | 1 | Read request to the result FIFO |
| res_bcd_o | output | 16 | Result read from the FIFO, four BCD digits |
| res_valid_o | output | 1 | One-cycle strobe for res_bcd_o |
| fifo_full_o | output | 1 | FIFO holds 4 results |
| fifo_empty_o | output | 1 | FIFO holds no result |
| busy_o | output | 1 | Measurement in progress |
| timeout_o | output | 1 | Sticky: last measurement saturated at 9999 |

## Verification
The hardest case to reach is the saturated measurement. It takes ten thousand counting cycles with no echo edge, and the cascade from 9999 must not wrap. The stimulus raises the echo before counting starts and holds it high for the whole run. This gives the counter no rising edge, and it also shows that a level does not stop the count. The same run then checks that a transmit enable arriving after the stop is ignored. A second hard case is the dropped fifth write, which needs four back-to-back measurements with no reads between them.

// File: rtl/tof_pkg.sv
package tof_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tof_state_e;
endpackage

// File: rtl/tof_echo_sync.sv
module tof_echo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], async_i};
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sync[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/tof_bcd_counter.sv
module tof_bcd_counter #(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * tof_pkg::DIGIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero_i,
    input  logic         inc_i,
    output logic [W-1:0] value_o,
    output logic         max_o
);
    typedef struct packed {
        logic [DIGITS-1:0][tof_pkg::DIGIT_W-1:0] dig;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [DIGITS-1:0] nine;
    logic [DIGITS:0]   carry;

    for (genvar g = 0; g < DIGITS; g++) begin : g_nine
        assign nine[g] = (c_q.dig[g] == tof_pkg::DIGIT_W'(9));
    end

    always_comb begin
        c_d      = c_q;
        carry[0] = inc_i;
        for (int i = 0; i < DIGITS; i++) begin
            carry[i+1] = carry[i] & nine[i];
            if (carry[i]) begin
                c_d.dig[i] = nine[i] ? '0 : c_q.dig[i] + 1'b1;
            end
        end
        if (zero_i) c_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign value_o = c_q.dig;
    assign max_o   = &nine;
endmodule

// File: rtl/tof_fifo.sv
module tof_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         rd_i,
    output logic [W-1:0] rdata_o,
    output logic         rvalid_o,
    output logic         full_o,
    output logic         empty_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wptr;
        logic [AW:0]             rptr;
        logic [W-1:0]            rdata;
        logic                    rvalid;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  full, empty;

    assign empty = (f_q.wptr == f_q.rptr);
    assign full  = (f_q.wptr[AW] != f_q.rptr[AW]) &&
                   (f_q.wptr[AW-1:0] == f_q.rptr[AW-1:0]);

    always_comb begin
        f_d        = f_q;
        f_d.rvalid = 1'b0;
        if (wr_i && !full) begin
            f_d.mem[f_q.wptr[AW-1:0]] = wdata_i;
            f_d.wptr                  = f_q.wptr + 1'b1;
        end
        if (rd_i && !empty) begin
            f_d.rdata  = f_q.mem[f_q.rptr[AW-1:0]];
            f_d.rvalid = 1'b1;
            f_d.rptr   = f_q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rdata_o  = f_q.rdata;
    assign rvalid_o = f_q.rvalid;
    assign full_o   = full;
    assign empty_o  = empty;
endmodule

// File: rtl/tof_timer.sv
module tof_timer #(
    parameter int DIGITS      = 4,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int W = DIGITS * tof_pkg::DIGIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en_i,
    input  logic         echo_i,
    input  logic         clr_i,
    input  logic         rd_en_i,
    output logic [W-1:0] res_bcd_o,
    output logic         res_valid_o,
    output logic         fifo_full_o,
    output logic         fifo_empty_o,
    output logic         busy_o,
    output logic         timeout_o
);
    import tof_pkg::*;

    typedef struct packed {
        tof_state_e st;
        logic       tmo;
    } ctl_t;

    ctl_t   c_d, c_q;
    logic   echo_rise;
    logic   cnt_max;
    logic   cnt_inc;
    logic   stop_echo, stop_max, wr_req;
    logic [W-1:0] cnt_val;

    tof_echo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (echo_i),
        .rise_o  (echo_rise)
    );

    tof_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .zero_i  (clr_i),
        .inc_i   (cnt_inc),
        .value_o (cnt_val),
        .max_o   (cnt_max)
    );

    tof_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_req),
        .wdata_i  (cnt_val),
        .rd_i     (rd_en_i),
        .rdata_o  (res_bcd_o),
        .rvalid_o (res_valid_o),
        .full_o   (fifo_full_o),
        .empty_o  (fifo_empty_o)
    );

    always_comb begin
        stop_echo = (c_q.st == ST_RUN) && echo_rise;
        stop_max  = (c_q.st == ST_RUN) && !echo_rise && cnt_max;
        wr_req    = !clr_i && (stop_echo || stop_max);
        cnt_inc   = (c_q.st == ST_RUN) && !clr_i && !stop_echo && !stop_max;

        c_d = c_q;
        if (clr_i) begin
            c_d.st  = ST_IDLE;
            c_d.tmo = 1'b0;
        end else begin
            case (c_q.st)
                ST_IDLE: if (tx_en_i) c_d.st = ST_RUN;
                ST_RUN: begin
                    if (stop_echo || stop_max) c_d.st = ST_DONE;
                    if (stop_max)              c_d.tmo = 1'b1;
                end
                default: c_d.st = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, tmo: 1'b0};
        else        c_q <= c_d;
    end

    assign busy_o    = (c_q.st == ST_RUN);
    assign timeout_o = c_q.tmo;
endmodule

// File: rtl/tof_timer_chk.sv
module tof_timer_chk #(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_i,
    input logic         rd_en_i,
    input logic [W-1:0] res_bcd_o,
    input logic         res_valid_o,
    input logic         fifo_full_o,
    input logic         fifo_empty_o,
    input logic         busy_o,
    input logic         timeout_o
);
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full_o && fifo_empty_o));

    p_valid_from_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(rd_en_i && !fifo_empty_o));

    p_timeout_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !clr_i) |=> timeout_o);

    p_timeout_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !busy_o);

    p_clr_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!busy_o && !timeout_o));

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid_o |-> (res_bcd_o[4*g +: 4] <= 4'd9));
    end
endmodule

bind tof_timer tof_timer_chk #(.DIGITS(DIGITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .rd_en_i      (rd_en_i),
    .res_bcd_o    (res_bcd_o),
    .res_valid_o  (res_valid_o),
    .fifo_full_o  (fifo_full_o),
    .fifo_empty_o (fifo_empty_o),
    .busy_o       (busy_o),
    .timeout_o    (timeout_o)
);

// File: tb/tof_timer_tb_top.sv
`timescale 1ns/1ps
module tof_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, echo = 1'b0, clr = 1'b0, rd = 1'b0;
    logic [15:0] res_bcd;
    logic res_valid, full, empty, busy, tmo;

    int checks = 0;
    int failures = 0;
    int model_cnt = 0;
    bit finished = 1'b0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    tof_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .echo_i(echo),
        .clr_i(clr), .rd_en_i(rd), .res_bcd_o(res_bcd),
        .res_valid_o(res_valid), .fifo_full_o(full), .fifo_empty_o(empty),
        .busy_o(busy), .timeout_o(tmo)
    );

    function automatic logic [15:0] to_bcd(int v);
        logic [15:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard compare of every strobed result (R9, R4, R2)
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9 actual=%0h expected=no strobe", res_bcd);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (res_bcd !== e) begin
                    failures++;
                    $display("FAIL R4 actual=%0h expected=%0h", res_bcd, e);
                end
            end
        end
    end

    task automatic clear_blk();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // driver: echo high before edge m after start at edge 0 -> result m+1
    task automatic measure(int m);
        tx_en = 1'b1;
        @(negedge clk);
        tx_en = 1'b0;
        check("R2 busy after start", 32'(busy), 32'd1);
        repeat (m - 1) @(negedge clk);
        echo = 1'b1;
        repeat (4) @(negedge clk);
        echo = 1'b0;
        if (model_cnt < 4) begin
            exp_q.push_back(to_bcd(m + 1));
            model_cnt++;
        end
        repeat (3) @(negedge clk);
        check("R2 busy after stop", 32'(busy), 32'd0);
    endtask

    task automatic read_one();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        if (model_cnt > 0) model_cnt--;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty", 32'(empty), 32'd1);
        check("R1 full", 32'(full), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 timeout", 32'(tmo), 32'd0);
        check("R1 valid", 32'(res_valid), 32'd0);

        measure(5);  clear_blk();
        measure(12); clear_blk();
        measure(123);
        check("R8 not empty", 32'(empty), 32'd0);
        repeat (3) read_one();
        check("R8 drained", 32'(empty), 32'd1);

        // R3: echo while idle writes nothing
        clear_blk();
        echo = 1'b1;
        repeat (5) @(negedge clk);
        echo = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 idle echo no write", 32'(empty), 32'd1);
        check("R3 idle echo busy", 32'(busy), 32'd0);

        // R5 + R3: echo held high from before start -> no rise -> timeout
        echo = 1'b1;
        repeat (4) @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        tx_en = 1'b0;
        repeat (9990) @(negedge clk);
        check("R3 level does not stop", 32'(busy), 32'd1);
        repeat (20) @(negedge clk);
        check("R5 stopped", 32'(busy), 32'd0);
        check("R5 timeout set", 32'(tmo), 32'd1);
        exp_q.push_back(16'h9999);
        model_cnt++;
        echo = 1'b0;
        repeat (3) @(negedge clk);

        // R6: start ignored after stop
        tx_en = 1'b1;
        @(negedge clk);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 busy stays low", 32'(busy), 32'd0);
        read_one();
        check("R6 no extra write", 32'(empty), 32'd1);
        check("R5 timeout sticky", 32'(tmo), 32'd1);
        clear_blk();
        check("R7 timeout cleared", 32'(tmo), 32'd0);

        // R7: abort a running measurement
        tx_en = 1'b1;
        @(negedge clk);
        tx_en = 1'b0;
        repeat (20) @(negedge clk);
        clear_blk();
        check("R7 abort busy", 32'(busy), 32'd0);
        check("R7 abort no write", 32'(empty), 32'd1);

        // R8: fill, drop fifth, keep order across clears
        for (int k = 2; k <= 5; k++) begin
            measure(k);
            clear_blk();
        end
        check("R8 full", 32'(full), 32'd1);
        measure(6);
        clear_blk();
        check("R8 still full", 32'(full), 32'd1);
        repeat (4) read_one();
        check("R8 empty after drain", 32'(empty), 32'd1);

        // R9: read while empty -> no strobe
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R9 no strobe on empty", 32'(res_valid), 32'd0);
        repeat (3) @(negedge clk);

        check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule